// File: doc/BRIEF.md
# Compare-Match Pulse Width Modulator

This block turns a free-running counter and a programmable compare value into one pulse width modulated output and a compare interrupt. The counter advances once for each timer tick, a single-cycle enable, and wraps every 2^CNT_W ticks (256 ticks with the default 8-bit width). Each tick carries a phase index equal to the counter value plus one, so the index runs from 1 to 256. The output is high while that index is no greater than the compare value. The compare value therefore gives the number of high ticks in each period directly, and a value of zero holds the output low.

The compare input is double-buffered. The period in progress keeps the value it started with, and a new value is taken only when the counter wraps, or at any time while the block is idle. One tick per period is the compare match. It can raise a one-cycle interrupt pulse and a sticky flag that software clears. A sleep input can freeze the counter and the output unless a no-stop input is set.

Control runs through a three-state machine. IDLE holds the counter at zero, keeps the output low and lets the shadow copy follow the compare input. RUN counts ticks. FROZEN holds the counter and the output. The transitions are:
- ENABLE (IDLE to RUN), taken when enable is high and no freeze is requested.
- HALT (any state to IDLE), taken when enable is low.
- SLEEP (RUN or IDLE to FROZEN), taken when enable is high, sleep is high and no_stop is low.
- WAKE (FROZEN to RUN), taken when the freeze condition falls while enable stays high.

Every state goes to the state these inputs select at the next clock edge.

Top module: `pwm_timer`

## Requirements
- R1: A synchronous reset puts the block in IDLE with the counter at 0. pwm_out, irq_pulse and irq_flag are all 0 after that edge.
- R2: In RUN or FROZEN, pwm_out is 1 exactly when (counter + 1) is less than or equal to the active compare value. In IDLE it is 0. One period is 256 ticks.
- R3: With a steady compare value C and tick high every cycle, any 256 consecutive RUN cycles contain exactly C cycles with pwm_out high.
- R4: C = 0 gives a constant low output. C = 255 gives 255 high cycles and one low cycle per period.
- R5: A change on cmp_val has no effect on the period in progress. The active value is reloaded only on the tick that wraps the counter from 255 to 0, or on every edge while in IDLE.
- R6: A compare match is a counted tick where the 8-bit value (counter + 1) equals the active compare value. With C = 0 this is the tick at counter 255. When irq_mask is 0, irq_pulse is 1 for the one cycle after the match edge.
- R7: While irq_mask is 1 at a match edge, neither irq_pulse nor irq_flag is raised.
- R8: irq_flag goes to 1 with each unmasked match and stays 1 until an edge where irq_clr is 1. If a set and a clear arrive on the same edge, the set wins.
- R9: With enable 1, sleep 1 and no_stop 0, the state becomes FROZEN. The counter and pwm_out then hold their values. With no_stop 1, counting continues during sleep.
- R10: With enable 0 the next state is IDLE. On the following edge the counter returns to 0, and the output stays low.
- R11: The counter advances by one only on edges where tick is 1 in RUN, and otherwise holds (outside IDLE).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable |
| tick | input | 1 | Timer clock enable, one pulse per count |
| cmp_val | input | CNT_W | Compare value, loaded at wrap or while idle |
| irq_mask | input | 1 | 1 masks the compare interrupt |
| sleep | input | 1 | Sleep request |
| no_stop | input | 1 | 1 keeps counting during sleep |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| pwm_out | output | 1 | Modulated output |
| irq_pulse | output | 1 | One-cycle compare interrupt |
| irq_flag | output | 1 | Sticky compare interrupt flag |

## Verification
Every input takes effect at the next clock edge, and the results appear in that edge's delta with no further pipeline stage. This holds for irq_pulse and irq_flag, which register the match, and for pwm_out, which is decoded from the state, counter and shadow registers that the same edge updates. An enable, sleep or no_stop change alters the state first, so it reaches the counter one edge later. The bench drives inputs on the falling edge and computes the expected outputs for the coming rising edge from the requirements. It queues those expected values, and a monitor compares them 1 ns after that rising edge, so every result is checked in the cycle it is due.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/pwm_ctrl_fsm.sv
`timescale 1ns/1ps
module pwm_ctrl_fsm
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       sleep,
    input  logic       no_stop,
    input  logic       tick,
    output pwm_state_e state_q,
    output logic       idle,
    output logic       advance
);
    pwm_state_e state_d;
    logic       freeze_req;

    assign freeze_req = sleep && !no_stop;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = freeze_req ? ST_FROZEN : ST_RUN;
            end
            ST_RUN: begin
                if (!enable)         state_d = ST_IDLE;
                else if (freeze_req) state_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (!enable)          state_d = ST_IDLE;
                else if (!freeze_req) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        idle    = (state_q == ST_IDLE);
        advance = (state_q == ST_RUN) && tick;
    end

    // R9: a freeze request with enable present lands in FROZEN
    p_freeze_entry_r9: assert property (@(posedge clk) disable iff (rst)
        (enable && sleep && !no_stop) |=> (state_q == ST_FROZEN));

    // R10: dropping enable always returns to IDLE
    p_halt_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             advance,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             pwm_level,
    output logic             match
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] phase_next;
    logic             wrap;

    assign phase_next = cnt_q + 1'b1;
    assign wrap       = advance && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            if (idle)         cnt_q <= '0;
            else if (advance) cnt_q <= phase_next;
            if (idle || wrap) act_q <= cmp_val;
        end
    end

    assign pwm_level = !idle && (cnt_q < act_q);
    assign match     = advance && (phase_next == act_q);

    // R11: one step per counted tick
    p_step_r11: assert property (@(posedge clk) disable iff (rst)
        advance |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R11 / R9: no tick outside IDLE means the counter holds
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!idle && !advance) |=> $stable(cnt_q));

    // R5: shadow value frozen between wraps
    p_shadow_r5: assert property (@(posedge clk) disable iff (rst)
        (!idle && !wrap) |=> $stable(act_q));

    // R10: idle clears the counter
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        idle |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_irq.sv
`timescale 1ns/1ps
module pwm_irq (
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic irq_mask,
    input  logic irq_clr,
    output logic irq_pulse,
    output logic irq_flag
);
    logic raise;

    assign raise = match && !irq_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            irq_pulse <= raise;
            if (raise)        irq_flag <= 1'b1;
            else if (irq_clr) irq_flag <= 1'b0;
        end
    end

    // R7: a masked edge never produces a pulse
    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        irq_mask |=> !irq_pulse);

    // R8: flag is sticky until cleared
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R8: every pulse is mirrored in the flag
    p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_flag);
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             irq_mask,
    input  logic             sleep,
    input  logic             no_stop,
    input  logic             irq_clr,
    output logic             pwm_out,
    output logic             irq_pulse,
    output logic             irq_flag
);
    pwm_state_e state_q;
    logic       idle;
    logic       advance;
    logic       match;

    pwm_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .sleep   (sleep),
        .no_stop (no_stop),
        .tick    (tick),
        .state_q (state_q),
        .idle    (idle),
        .advance (advance)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .advance   (advance),
        .cmp_val   (cmp_val),
        .pwm_level (pwm_out),
        .match     (match)
    );

    pwm_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .match     (match),
        .irq_mask  (irq_mask),
        .irq_clr   (irq_clr),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

    // R1: reset leaves the output and interrupt quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!pwm_out && !irq_pulse && !irq_flag));

    // R2: output is low whenever the machine is idle
    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !pwm_out);
endmodule

// File: tb/tb_pwm_timer.sv
`timescale 1ns/1ps
module tb_pwm_timer;
    localparam int W = 8;

    typedef struct {
        logic  pwm;
        logic  pulse;
        logic  flag;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst, enable, tick, irq_mask, sleep, no_stop, irq_clr;
    logic [W-1:0] cmp_val;
    logic         pwm_out, irq_pulse, irq_flag;

    logic         d_rst = 1'b1, d_en = 1'b0, d_tick = 1'b0, d_mask = 1'b0;
    logic         d_sleep = 1'b0, d_nostop = 1'b0, d_clr = 1'b0;
    logic [W-1:0] d_cmp = '0;
    string        cur_tag = "R1";

    int tests = 0;
    int fails = 0;
    exp_t sb[$];

    // reference model state: 0 idle, 1 run, 2 frozen
    int           m_st = 0;
    logic [W-1:0] m_cnt = '0, m_act = '0;
    logic         m_flag = 1'b0;

    always #2 clk = ~clk;

    initial begin
        rst = 1'b1; enable = 1'b0; tick = 1'b0; irq_mask = 1'b0;
        sleep = 1'b0; no_stop = 1'b0; irq_clr = 1'b0; cmp_val = '0;
    end

    pwm_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick), .cmp_val(cmp_val),
        .irq_mask(irq_mask), .sleep(sleep), .no_stop(no_stop), .irq_clr(irq_clr),
        .pwm_out(pwm_out), .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    task automatic cyc();
        exp_t         e;
        logic         counted, hit;
        logic [W-1:0] phase;
        @(negedge clk);
        rst = d_rst; enable = d_en; tick = d_tick; irq_mask = d_mask;
        sleep = d_sleep; no_stop = d_nostop; irq_clr = d_clr; cmp_val = d_cmp;
        if (rst) begin
            m_st = 0; m_cnt = '0; m_act = '0; m_flag = 1'b0;
            e.pulse = 1'b0;
        end else begin
            counted = (m_st == 1) && tick;
            phase   = m_cnt + 1'b1;
            hit     = counted && (phase == m_act) && !irq_mask;
            e.pulse = hit;
            if (hit)          m_flag = 1'b1;
            else if (irq_clr) m_flag = 1'b0;
            if (m_st == 0 || (counted && m_cnt == 8'd255)) m_act = cmp_val;
            if (m_st == 0)    m_cnt = '0;
            else if (counted) m_cnt = phase;
            m_st = !enable ? 0 : ((sleep && !no_stop) ? 2 : 1);
        end
        e.flag = m_flag;
        e.pwm  = (m_st != 0) && ({1'b0, m_cnt} + 9'd1 <= {1'b0, m_act});
        e.tag  = cur_tag;
        sb.push_back(e);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic check(string req, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // monitor: compare outputs 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            tests++;
            if (pwm_out !== e.pwm) begin
                fails++;
                $display("FAIL R2 (%s) pwm_out got %0b expected %0b", e.tag, pwm_out, e.pwm);
            end
            tests++;
            if (irq_pulse !== e.pulse) begin
                fails++;
                $display("FAIL R6 (%s) irq_pulse got %0b expected %0b", e.tag, irq_pulse, e.pulse);
            end
            tests++;
            if (irq_flag !== e.flag) begin
                fails++;
                $display("FAIL R8 (%s) irq_flag got %0b expected %0b", e.tag, irq_flag, e.flag);
            end
        end
    end

    // count high cycles over one full period of ticks
    task automatic measure(string req, int exp_high);
        int hi = 0;
        for (int i = 0; i < 256; i++) begin
            cyc();
            @(posedge clk);
            #1;
            if (pwm_out === 1'b1) hi++;
        end
        check(req, hi, exp_high);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_tag = "R1"; d_rst = 1'b1; d_en = 1'b1; d_tick = 1'b1; d_cmp = 8'd100;
        run(3);
        @(posedge clk); #1;
        check("R1 pwm_out", pwm_out, 0);
        check("R1 irq_flag", irq_flag, 0);
        d_rst = 1'b0;

        // R3: 100 high ticks per period
        cur_tag = "R3"; run(300);
        measure("R3 high count C=100", 100);

        // R5: change mid-period, no effect until wrap
        cur_tag = "R5"; d_cmp = 8'd0; run(40);
        d_cmp = 8'd30; run(300);
        measure("R5 high count after reload C=30", 30);

        // R4: extremes
        cur_tag = "R4"; d_cmp = 8'd0; run(300);
        measure("R4 high count C=0", 0);
        d_cmp = 8'd255; run(300);
        measure("R4 high count C=255", 255);

        // R11: sparse ticks
        cur_tag = "R11"; d_cmp = 8'd7;
        for (int i = 0; i < 600; i++) begin
            d_tick = (i % 3 == 0);
            cyc();
        end
        d_tick = 1'b1;

        // R7: masked matches
        cur_tag = "R7"; d_mask = 1'b1; d_clr = 1'b1; run(3); d_clr = 1'b0;
        run(520);
        @(posedge clk); #1;
        check("R7 flag stays clear while masked", irq_flag, 0);
        d_mask = 1'b0;

        // R8: sticky flag, clear, set-wins with clear held
        cur_tag = "R8"; run(300);
        d_clr = 1'b1; run(2); d_clr = 1'b0; run(100);
        d_clr = 1'b1; run(300); d_clr = 1'b0;

        // R9: freeze, then no-stop sleep
        cur_tag = "R9"; d_cmp = 8'd128; run(300);
        d_sleep = 1'b1; run(30);
        d_nostop = 1'b1; run(300);
        d_sleep = 1'b0; d_nostop = 1'b0; run(20);

        // R10: disable and re-enable
        cur_tag = "R10"; d_en = 1'b0; run(10);
        @(posedge clk); #1;
        check("R10 pwm_out low when idle", pwm_out, 0);
        d_en = 1'b1; d_cmp = 8'd60; run(40);

        // R1: reset in the middle of a run
        cur_tag = "R1"; d_rst = 1'b1; run(2); d_rst = 1'b0; run(30);

        run(2);
        @(posedge clk); #2;
        check("R2 scoreboard drained", sb.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule